// File: doc/BRIEF.md
# Pseudo-SRAM Power Sequencer

This block sits on the host side of a pseudo-SRAM. It drives the memory's two chip-enable lines through the initialisation that must follow power-up, and through entering and leaving the device's low-power state. The high-active enable is the power control: while it is low the device is powered down. The low-active enable selects the device for accesses. In normal operation the low-active enable is passed straight through from the main bus controller. During any sequencing interval the block forces it high, and it drops a ready output so that the bus controller holds off.

The host raises a sleep request to power the device down and a wake request to bring it back. A sleep request that arrives while the bus controller has an access open is held until the controller deselects the device. A wake request that arrives before the minimum power-down time has passed is also held, and it is served as soon as that time has elapsed. The minimum hold after wake depends on the retention mode that is programmed at the moment of entry. With no retention, the full long hold applies. With either partial-retention mode, only a short hold applies. Every interval is a cycle count derived from nanosecond parameters and the clock-period parameter, rounded up to whole cycles and never less than one.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is asserted, enHigh is 0, enLowN is 1, ready is 0 and dataHiZ is 1.
- R2: After reset, enHigh stays 0 while supplyGood is 0. It rises on the PWRUP_CYC-th rising edge at which supplyGood is sampled 1, where PWRUP_CYC = ceil(PWRUP_LOW_NS / CLK_PERIOD_NS), which is 2500 at the defaults.
- R3: After the power-up rise of enHigh, enLowN stays 1 and ready stays 0 for LONG_CYC edges (15000 at the defaults). Ready then becomes 1.
- R4: While ready is 1, enLowN equals ctrlCeN. While ready is 0, enLowN is 1.
- R5: A sleepReq sampled 1 while ready is 1 is remembered. While ctrlCeN is 0 the block stays ready. On the first edge at which ctrlCeN is 1, ready falls.
- R6: sleepReq has no effect while ready is 0 during power-up, and wakeReq has no effect while ready is 1.
- R7: At the edge where ready falls for entry, enHigh stays 1 with enLowN 1 for SETUP_CYC edges (1 at the defaults). Then enHigh falls.
- R8: enHigh stays 0 for at least ENTRY_CYC edges (4 at the defaults). A wakeReq sampled during that interval is held, and enHigh rises exactly ENTRY_CYC edges after it fell.
- R9: After the entry interval, enHigh rises on the first edge at which wakeReq is sampled 1.
- R10: After enHigh rises on wake, ready stays 0 for SHORT_CYC edges (4 at the defaults) if retainMode was nonzero at the edge where ready fell. If retainMode was 2'b00 at that edge, ready stays 0 for LONG_CYC edges. Later changes to retainMode do not alter the hold.
- R11: dataHiZ is 1 whenever ready is 0, including the whole time enHigh is 0. dataHiZ is 0 whenever ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| supplyGood | input | 1 | Memory supply has reached its operating level |
| sleepReq | input | 1 | Request to power the memory down |
| wakeReq | input | 1 | Request to bring the memory out of power-down |
| retainMode | input | 2 | Programmed retention mode: 00 no retention, any other value partial retention |
| ctrlCeN | input | 1 | Low-active select from the bus controller; 0 means an access is in progress |
| enHigh | output | 1 | High-active chip enable to the memory (power control) |
| enLowN | output | 1 | Low-active chip enable to the memory |
| dataHiZ | output | 1 | Data bus must be released (high impedance) |
| ready | output | 1 | Memory is available to the bus controller |

## Verification
The power-down cycle is tried with a table of request patterns. Each pattern pairs a retention mode with a wake time. A wake at once or inside the minimum low time checks that the request is held and served when the entry interval ends. A wake just after the interval, and one well after it, check that the request is served on the very next edge. Varying the mode and then changing it while the device is powered down checks that the exit hold follows the value captured at entry and not the live input. Directed tests cover the power-up intervals, requests that must be ignored, and a sleep request held back by an open access.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

  typedef enum logic [2:0] {
    S_PUP_LOW,
    S_PUP_HOLD,
    S_ACTIVE,
    S_SETUP,
    S_ENTRY,
    S_DOWN,
    S_EXIT
  } seqState_t;

  typedef enum logic [2:0] {
    D_PWRUP,
    D_LONG,
    D_SETUP,
    D_ENTRY,
    D_EXIT
  } durSel_t;

  typedef struct packed {
    logic    load;
    durSel_t sel;
    logic    capMode;
    logic    armSleep;
    logic    clrSleep;
    logic    armWake;
    logic    clrWake;
  } seqStrobe_t;

  function automatic int nsToCycles(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/psram_pwr_dp.sv
module psram_pwr_dp
  import psram_pwr_pkg::*;
#(
  parameter int PWRUP_CYC = 2500,
  parameter int LONG_CYC  = 15000,
  parameter int SHORT_CYC = 4,
  parameter int SETUP_CYC = 1,
  parameter int ENTRY_CYC = 4,
  parameter int MODE_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        str,
  input  logic              sleepReq,
  input  logic              wakeReq,
  input  logic [MODE_W-1:0] retainMode,
  output logic              cntDone,
  output logic              sleepSeen,
  output logic              wakeSeen,
  output logic              shortExit
);

  localparam int CNT_W = $clog2(PWRUP_CYC + LONG_CYC + SHORT_CYC + SETUP_CYC + ENTRY_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;
  logic             sleepPend;
  logic             wakePend;

  always_comb begin
    case (str.sel)
      D_PWRUP: loadVal = CNT_W'(PWRUP_CYC - 1);
      D_LONG:  loadVal = CNT_W'(LONG_CYC - 1);
      D_SETUP: loadVal = CNT_W'(SETUP_CYC - 1);
      D_ENTRY: loadVal = CNT_W'(ENTRY_CYC - 1);
      D_EXIT:  loadVal = shortExit ? CNT_W'(SHORT_CYC - 1) : CNT_W'(LONG_CYC - 1);
      default: loadVal = CNT_W'(LONG_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= CNT_W'(PWRUP_CYC - 1);
    end else if (str.load) begin
      cnt <= loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntDone = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepPend <= 1'b0;
      wakePend  <= 1'b0;
      shortExit <= 1'b0;
    end else begin
      if (str.clrSleep)                 sleepPend <= 1'b0;
      else if (str.armSleep && sleepReq) sleepPend <= 1'b1;
      if (str.clrWake)                  wakePend <= 1'b0;
      else if (str.armWake && wakeReq)  wakePend <= 1'b1;
      if (str.capMode)                  shortExit <= (retainMode != '0);
    end
  end

  assign sleepSeen = sleepPend | sleepReq;
  assign wakeSeen  = wakePend | wakeReq;

  // R8: a wake seen during entry/down is held until served
  p_wake_latch_r8: assert property (@(posedge clk) disable iff (!rstN)
    (str.armWake && !str.clrWake && wakeReq) |=> wakePend);

  // R10: the exit-hold choice only changes at capture
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !str.capMode |=> $stable(shortExit));

endmodule

// File: rtl/psram_pwr_ctl.sv
module psram_pwr_ctl
  import psram_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyGood,
  input  logic       ctrlCeN,
  input  logic       cntDone,
  input  logic       sleepSeen,
  input  logic       wakeSeen,
  output seqStrobe_t str,
  output logic       enHigh,
  output logic       enLowN,
  output logic       ready,
  output logic       dataHiZ
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_PUP_LOW;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    str       = '{load: 1'b0, sel: D_PWRUP, capMode: 1'b0, armSleep: 1'b0,
                  clrSleep: 1'b0, armWake: 1'b0, clrWake: 1'b0};
    case (state)
      S_PUP_LOW: begin
        if (!supplyGood) begin
          str.load = 1'b1;
          str.sel  = D_PWRUP;
        end else if (cntDone) begin
          nextState = S_PUP_HOLD;
          str.load  = 1'b1;
          str.sel   = D_LONG;
        end
      end
      S_PUP_HOLD: begin
        if (cntDone) nextState = S_ACTIVE;
      end
      S_ACTIVE: begin
        if (sleepSeen && ctrlCeN) begin
          nextState    = S_SETUP;
          str.load     = 1'b1;
          str.sel      = D_SETUP;
          str.capMode  = 1'b1;
          str.clrSleep = 1'b1;
        end else begin
          str.armSleep = 1'b1;
        end
      end
      S_SETUP: begin
        if (cntDone) begin
          nextState = S_ENTRY;
          str.load  = 1'b1;
          str.sel   = D_ENTRY;
        end
      end
      S_ENTRY: begin
        str.armWake = 1'b1;
        if (cntDone) begin
          if (wakeSeen) begin
            nextState   = S_EXIT;
            str.load    = 1'b1;
            str.sel     = D_EXIT;
            str.clrWake = 1'b1;
          end else begin
            nextState = S_DOWN;
          end
        end
      end
      S_DOWN: begin
        str.armWake = 1'b1;
        if (wakeSeen) begin
          nextState   = S_EXIT;
          str.load    = 1'b1;
          str.sel     = D_EXIT;
          str.clrWake = 1'b1;
        end
      end
      S_EXIT: begin
        if (cntDone) nextState = S_ACTIVE;
      end
      default: nextState = S_PUP_LOW;
    endcase
  end

  always_comb begin
    enHigh  = !(state == S_PUP_LOW || state == S_ENTRY || state == S_DOWN);
    ready   = (state == S_ACTIVE);
    enLowN  = ready ? ctrlCeN : 1'b1;
    dataHiZ = !ready;
  end

  // R4: device never selected while the power control is low
  p_deselect_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    !enHigh |-> enLowN);

  // R5: an open access keeps the block in service
  p_defer_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ACTIVE && !ctrlCeN) |=> (state == S_ACTIVE));

  // R8: the minimum low time is not cut short
  p_entry_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ENTRY && !cntDone) |=> !enHigh);

  // R10: ready stays low through the exit hold
  p_exit_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EXIT && !cntDone) |=> !ready);

  // R11: bus released whenever powered down
  p_hiz_down_r11: assert property (@(posedge clk) disable iff (!rstN)
    !enHigh |-> dataHiZ);

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_pwr_pkg::*;
#(
  parameter int CLK_PERIOD_NS  = 20,
  parameter int PWRUP_LOW_NS   = 50000,
  parameter int LONG_HOLD_NS   = 300000,
  parameter int SHORT_HOLD_NS  = 65,
  parameter int ENTRY_SETUP_NS = 10,
  parameter int ENTRY_HOLD_NS  = 65,
  parameter int MODE_W         = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyGood,
  input  logic              sleepReq,
  input  logic              wakeReq,
  input  logic [MODE_W-1:0] retainMode,
  input  logic              ctrlCeN,
  output logic              enHigh,
  output logic              enLowN,
  output logic              dataHiZ,
  output logic              ready
);

  localparam int PWRUP_CYC = nsToCycles(PWRUP_LOW_NS, CLK_PERIOD_NS);
  localparam int LONG_CYC  = nsToCycles(LONG_HOLD_NS, CLK_PERIOD_NS);
  localparam int SHORT_CYC = nsToCycles(SHORT_HOLD_NS, CLK_PERIOD_NS);
  localparam int SETUP_CYC = nsToCycles(ENTRY_SETUP_NS, CLK_PERIOD_NS);
  localparam int ENTRY_CYC = nsToCycles(ENTRY_HOLD_NS, CLK_PERIOD_NS);

  seqStrobe_t str;
  logic       cntDone;
  logic       sleepSeen;
  logic       wakeSeen;
  logic       shortExit;

  psram_pwr_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .supplyGood(supplyGood),
    .ctrlCeN   (ctrlCeN),
    .cntDone   (cntDone),
    .sleepSeen (sleepSeen),
    .wakeSeen  (wakeSeen),
    .str       (str),
    .enHigh    (enHigh),
    .enLowN    (enLowN),
    .ready     (ready),
    .dataHiZ   (dataHiZ)
  );

  psram_pwr_dp #(
    .PWRUP_CYC(PWRUP_CYC),
    .LONG_CYC (LONG_CYC),
    .SHORT_CYC(SHORT_CYC),
    .SETUP_CYC(SETUP_CYC),
    .ENTRY_CYC(ENTRY_CYC),
    .MODE_W   (MODE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .str       (str),
    .sleepReq  (sleepReq),
    .wakeReq   (wakeReq),
    .retainMode(retainMode),
    .cntDone   (cntDone),
    .sleepSeen (sleepSeen),
    .wakeSeen  (wakeSeen),
    .shortExit (shortExit)
  );

endmodule

// File: tb/psram_pwr_seq_tb.sv
module psram_pwr_seq_tb;

  localparam int PERIOD    = 20;
  localparam int PWRUP_CYC = (50000 + PERIOD - 1) / PERIOD;
  localparam int LONG_CYC  = (300000 + PERIOD - 1) / PERIOD;
  localparam int SHORT_CYC = (65 + PERIOD - 1) / PERIOD;
  localparam int SETUP_CYC = (10 + PERIOD - 1) / PERIOD;
  localparam int ENTRY_CYC = (65 + PERIOD - 1) / PERIOD;

  typedef struct packed {
    logic [1:0] mode;
    int         wakeAt;
    int         expLow;
    int         expExit;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{mode: 2'd0, wakeAt: 0, expLow: ENTRY_CYC,     expExit: LONG_CYC},
    '{mode: 2'd1, wakeAt: 3, expLow: ENTRY_CYC,     expExit: SHORT_CYC},
    '{mode: 2'd2, wakeAt: 9, expLow: 10,            expExit: SHORT_CYC},
    '{mode: 2'd3, wakeAt: 4, expLow: ENTRY_CYC + 1, expExit: SHORT_CYC},
    '{mode: 2'd1, wakeAt: 0, expLow: ENTRY_CYC,     expExit: SHORT_CYC}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       supplyGood, sleepReq, wakeReq, ctrlCeN;
  logic [1:0] retainMode;
  logic       enHigh, enLowN, dataHiZ, ready;

  int total = 0;
  int fails = 0;
  int hizBad = 0;
  bit finished = 0;

  always #(PERIOD / 2) clk = ~clk;

  psram_pwr_seq u_dut (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .sleepReq(sleepReq),
    .wakeReq(wakeReq), .retainMode(retainMode), .ctrlCeN(ctrlCeN),
    .enHigh(enHigh), .enLowN(enLowN), .dataHiZ(dataHiZ), .ready(ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // which: 0 ready low, 1 enHigh low, 2 enHigh high, 3 ready high
  task automatic waitFor(input int which, output int n);
    bit hit;
    n = 0;
    hit = 0;
    while (!hit && n < 20000) begin
      @(negedge clk);
      n++;
      if (dataHiZ === ready) hizBad++;
      case (which)
        0: hit = (ready == 1'b0);
        1: hit = (enHigh == 1'b0);
        2: hit = (enHigh == 1'b1);
        default: hit = (ready == 1'b1);
      endcase
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int n;
    int bad;
    rstN = 1'b0; supplyGood = 1'b0; sleepReq = 1'b0; wakeReq = 1'b0;
    retainMode = 2'd0; ctrlCeN = 1'b1;
    repeat (3) @(negedge clk);
    chk(enHigh == 0 && enLowN == 1 && ready == 0 && dataHiZ == 1, "R1 reset outputs",
        {enHigh, enLowN, ready, dataHiZ}, 4'b0101);
    rstN = 1'b1;

    // power-up, with a sleep request that must be ignored
    sleepReq = 1'b1;
    @(negedge clk);
    sleepReq = 1'b0;
    repeat (19) @(negedge clk);
    chk(enHigh == 0, "R2 enHigh low without supply", enHigh, 0);
    supplyGood = 1'b1;
    waitFor(2, n);
    chk(n == PWRUP_CYC, "R2 power-up low time", n, PWRUP_CYC);
    chk(enLowN == 1 && ready == 0, "R3 hold after power-up", {enLowN, ready}, 2'b10);
    sleepReq = 1'b1;
    @(negedge clk);
    sleepReq = 1'b0;
    waitFor(3, n);
    chk(n + 1 == LONG_CYC, "R3 power-up hold length", n + 1, LONG_CYC);
    bad = 0;
    repeat (6) begin
      @(negedge clk);
      if (!ready) bad++;
    end
    chk(bad == 0, "R6 sleep during power-up ignored", bad, 0);

    // pass-through of the low-active select
    ctrlCeN = 1'b0;
    #1;
    chk(enLowN == 0, "R4 enLowN follows ctrlCeN low", enLowN, 0);
    @(negedge clk);
    ctrlCeN = 1'b1;
    #1;
    chk(enLowN == 1, "R4 enLowN follows ctrlCeN high", enLowN, 1);

    // wake while ready
    @(negedge clk);
    wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
    bad = 0;
    repeat (5) begin
      @(negedge clk);
      if (!ready || !enHigh) bad++;
    end
    chk(bad == 0, "R6 wake while ready ignored", bad, 0);

    // table of power-down cycles
    for (int i = 0; i < 5; i++) begin
      retainMode = VECS[i].mode;
      sleepReq = 1'b1;
      @(negedge clk);
      sleepReq = 1'b0;
      chk(ready == 0 && enHigh == 1 && enLowN == 1, "R7 entry setup outputs",
          {ready, enHigh, enLowN}, 3'b011);
      waitFor(1, n);
      chk(n == SETUP_CYC, "R7 setup length", n, SETUP_CYC);
      retainMode = (VECS[i].mode == 2'd0) ? 2'd1 : 2'd0;
      n = 0;
      bad = 0;
      while (1) begin
        if (n == VECS[i].wakeAt) wakeReq = 1'b1;
        @(negedge clk);
        wakeReq = 1'b0;
        n++;
        if (enLowN !== 1'b1) bad++;
        if (dataHiZ !== 1'b1) hizBad++;
        if (enHigh || n > 50) break;
      end
      chk(bad == 0, "R4 deselected while down", bad, 0);
      if (VECS[i].wakeAt < ENTRY_CYC)
        chk(n == VECS[i].expLow, "R8 held wake low time", n, VECS[i].expLow);
      else
        chk(n == VECS[i].expLow, "R9 wake after entry low time", n, VECS[i].expLow);
      waitFor(3, n);
      chk(n == VECS[i].expExit, "R10 exit hold by captured mode", n, VECS[i].expExit);
    end

    // sleep held back by an open access
    retainMode = 2'd2;
    ctrlCeN = 1'b0;
    sleepReq = 1'b1;
    @(negedge clk);
    sleepReq = 1'b0;
    bad = 0;
    repeat (8) begin
      @(negedge clk);
      if (!ready || enLowN) bad++;
    end
    chk(bad == 0, "R5 sleep deferred during access", bad, 0);
    ctrlCeN = 1'b1;
    waitFor(0, n);
    chk(n == 1, "R5 entry once access ends", n, 1);
    waitFor(1, n);
    wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
    waitFor(2, n);
    waitFor(3, n);
    chk(n == SHORT_CYC, "R10 short hold after deferred entry", n, SHORT_CYC);

    chk(hizBad == 0, "R11 dataHiZ tracks ready", hizBad, 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule